// File: doc/BRIEF.md
# Signature Stability Comparator

This block watches a stream of 16-bit measurement signatures and reports when two consecutive measurements disagree. It keeps the last accepted signature in a holding register. When the next one is accepted, it is compared with the held value, and the new value then replaces the held one. A difference produces a one-clock mismatch pulse. The same event starts a stretch counter that keeps a lamp-drive output high long enough to be seen.

A new signature is accepted only on a rising edge of the low-rate pacing strobe, and only while the signature-valid input is high. A strobe that stays high accepts one signature. The control is a two-state machine. ST_EMPTY means no signature is held; it is the state after reset. ST_ARMED means a previous signature is held. Transition T_FIRST takes ST_EMPTY to ST_ARMED on the first accept, and that accept only loads the register. Transition T_COMPARE keeps ST_ARMED in ST_ARMED on each later accept; it compares the new signature with the held one and then loads it. Reset returns the machine to ST_EMPTY.

Top module: `sig_stability_cmp`

## Requirements
- R1: A signature is accepted only at a clock edge where `strobe` is 1, `strobe` was 0 at the previous edge, and `sig_valid` is 1. At any other edge the held signature, `mismatch_pulse` and `lamp` are not affected by `sig_in`.
- R2: The first signature accepted after reset (T_FIRST) only loads the holding register and never produces a mismatch pulse or lights the lamp.
- R3: When an accepted signature differs in any bit from the held one (T_COMPARE), `mismatch_pulse` is 1 for exactly the one clock cycle that follows the accepting edge.
- R4: When an accepted signature equals the held one, no pulse is produced, and a lamp that is already counting continues its countdown unchanged.
- R5: Every accepted signature replaces the held one. The comparison at that edge uses the value held before the edge, so a repeated signature that follows a changed one gives no pulse.
- R6: After a mismatch, `lamp` is 1 for exactly LAMP_HOLD consecutive cycles, starting in the same cycle as `mismatch_pulse`.
- R7: A mismatch while `lamp` is still 1 restarts the count, so the lamp stays on for LAMP_HOLD cycles after the newest pulse.
- R8: Asserting `rst_n` low clears the held signature, the state (back to ST_EMPTY) and the lamp counter at once. The next accepted signature is then treated as the first.
- R9: A `strobe` held high for many cycles accepts only the signature present at its rising edge. Changes to `sig_in` while it stays high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 16 | Signature to evaluate |
| sig_valid | input | 1 | sig_in holds a finished signature |
| strobe | input | 1 | Low-rate pacing strobe; its rising edge starts a store-and-compare cycle |
| mismatch_pulse | output | 1 | One-cycle pulse when consecutive signatures differ |
| lamp | output | 1 | Stretched unstable indicator, high LAMP_HOLD cycles per mismatch |

## Verification
`mismatch_pulse` and `lamp` both rise in the cycle that follows an accepting edge. The held value changes at that same edge. `lamp` falls LAMP_HOLD cycles after it last rose. The bench has a reference model that updates on each rising clock edge from the inputs the bench drove on the preceding falling edge. Both outputs are compared with the model 1 ns after every rising edge, so each result is checked in exactly the cycle it is due. Scenarios are tagged so that a mismatch names the requirement under test.

// File: rtl/sigcmp_pkg.sv
package sigcmp_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_ARMED = 1'b1
    } cmp_state_e;
endpackage

// File: rtl/sigcmp_ctrl.sv
module sigcmp_ctrl
    import sigcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic sig_valid,
    input  logic differ,
    output logic accept,
    output logic pulse_now,
    output logic mismatch_pulse
);
    cmp_state_e state_q, state_d;
    logic       strobe_q;

    // strobe edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign accept = strobe && !strobe_q && sig_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state: T_FIRST and T_COMPARE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_ARMED;
            ST_ARMED: state_d = ST_ARMED;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        pulse_now = 1'b0;
        unique case (state_q)
            ST_EMPTY: pulse_now = 1'b0;
            ST_ARMED: pulse_now = accept && differ;
            default:  pulse_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mismatch_pulse <= 1'b0;
        else        mismatch_pulse <= pulse_now;
    end
endmodule

// File: rtl/sigcmp_store.sv
module sigcmp_store #(
    parameter int SIG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SIG_W-1:0] sig_in,
    output logic [SIG_W-1:0] held,
    output logic             differ
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= sig_in;
    end

    assign differ = |(held ^ sig_in);
endmodule

// File: rtl/sigcmp_stretch.sv
module sigcmp_stretch #(
    parameter int LAMP_HOLD = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic lamp
);
    localparam int CW = $clog2(LAMP_HOLD + 1);
    localparam logic [CW-1:0] LOADV = CW'(LAMP_HOLD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (trigger)        cnt_q <= LOADV;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign lamp = (cnt_q != '0);
endmodule

// File: rtl/sig_stability_cmp.sv
module sig_stability_cmp #(
    parameter int SIG_W     = 16,
    parameter int LAMP_HOLD = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIG_W-1:0] sig_in,
    input  logic             sig_valid,
    input  logic             strobe,
    output logic             mismatch_pulse,
    output logic             lamp
);
    logic             accept;
    logic             pulse_now;
    logic             differ;
    logic [SIG_W-1:0] held_sig;

    sigcmp_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe         (strobe),
        .sig_valid      (sig_valid),
        .differ         (differ),
        .accept         (accept),
        .pulse_now      (pulse_now),
        .mismatch_pulse (mismatch_pulse)
    );

    sigcmp_store #(.SIG_W(SIG_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .sig_in (sig_in),
        .held   (held_sig),
        .differ (differ)
    );

    sigcmp_stretch #(.LAMP_HOLD(LAMP_HOLD)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (pulse_now),
        .lamp    (lamp)
    );
endmodule

// File: rtl/sigcmp_checker.sv
module sigcmp_checker #(
    parameter int SIG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             accept,
    input logic [SIG_W-1:0] sig_in,
    input logic [SIG_W-1:0] held,
    input logic             mismatch_pulse,
    input logic             lamp
);
    AST_HELD_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) !accept |=> $stable(held)); // R1
    AST_PULSE_NEEDS_DIFF: assert property (@(posedge clk) disable iff (!rst_n) mismatch_pulse |-> $past(sig_in) != $past(held)); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mismatch_pulse |=> !mismatch_pulse); // R3
    AST_NO_PULSE_SAME: assert property (@(posedge clk) disable iff (!rst_n) (accept && sig_in == held) |=> !mismatch_pulse); // R4
    AST_HELD_LOADS: assert property (@(posedge clk) disable iff (!rst_n) accept |=> held == $past(sig_in)); // R5
    AST_LAMP_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mismatch_pulse |-> lamp); // R6
    AST_LAMP_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(lamp) |-> mismatch_pulse); // R6
    AST_RESET_DARK: assert property (@(posedge clk) !rst_n |-> (!lamp && !mismatch_pulse && held == '0)); // R8
endmodule

bind sig_stability_cmp sigcmp_checker #(.SIG_W(SIG_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (accept),
    .sig_in         (sig_in),
    .held           (held_sig),
    .mismatch_pulse (mismatch_pulse),
    .lamp           (lamp)
);

// File: tb/sim_sig_stability_cmp.sv
`timescale 1ns/1ps
module sim_sig_stability_cmp;
    localparam int HOLD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sig_in = '0;
    logic        sig_valid = 1'b0;
    logic        strobe = 1'b0;
    logic        mismatch_pulse, lamp;

    int    tests = 0;
    int    fails = 0;
    string phase = "R8";

    // reference model state
    bit    m_have = 0;
    int    m_prev = 0;
    bit    m_strb = 0;
    bit    m_pulse = 0;
    int    m_cnt = 0;

    always #2 clk = ~clk;

    sig_stability_cmp #(.SIG_W(16), .LAMP_HOLD(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .sig_valid(sig_valid),
        .strobe(strobe), .mismatch_pulse(mismatch_pulse), .lamp(lamp)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_have = 0; m_prev = 0; m_strb = 0; m_pulse = 0; m_cnt = 0;
        end else begin
            bit acc;
            acc = strobe && !m_strb && sig_valid;
            m_pulse = acc && m_have && (int'(sig_in) != m_prev);
            if (m_pulse) m_cnt = HOLD;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (acc) begin m_prev = int'(sig_in); m_have = 1; end
            m_strb = strobe;
        end
    end

    always @(posedge clk) begin
        #1;
        tests++;
        if (mismatch_pulse !== m_pulse) begin
            fails++;
            $display("FAIL %s mismatch_pulse actual=%b expected=%b at %0t", phase, mismatch_pulse, m_pulse, $time);
        end
        tests++;
        if (lamp !== (m_cnt > 0)) begin
            fails++;
            $display("FAIL %s lamp actual=%b expected=%b at %0t", phase, lamp, (m_cnt > 0), $time);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic present(logic [15:0] s);
        @(negedge clk);
        sig_in = s; sig_valid = 1'b1; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; sig_valid = 1'b0;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        phase = "R8"; idle(3); rst_n = 1'b1; idle(3);
        phase = "R2"; present(16'hA5A5); idle(5);
        phase = "R4"; present(16'hA5A5); idle(5);
        phase = "R3"; present(16'h0001); idle(4);
        phase = "R6"; idle(HOLD + 3);
        phase = "R5"; present(16'h0001); idle(4);
        phase = "R7"; present(16'hFFFF); idle(8); present(16'h8000); idle(6);
        phase = "R4"; present(16'h8000); idle(HOLD);
        phase = "R1";
        @(negedge clk); sig_in = 16'h1234; sig_valid = 1'b0; strobe = 1'b1;
        @(negedge clk); strobe = 1'b0; idle(3);
        @(negedge clk); sig_valid = 1'b1; sig_in = 16'h4321; idle(3);
        sig_valid = 1'b0; present(16'h8000); idle(4);
        phase = "R9";
        @(negedge clk); sig_in = 16'h0F0F; sig_valid = 1'b1; strobe = 1'b1;
        idle(2); sig_in = 16'hF0F0; idle(8);
        strobe = 1'b0; sig_valid = 1'b0; idle(HOLD + 2);
        present(16'hF0F0); idle(4);
        phase = "R8"; present(16'h0000); idle(3);
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2);
        present(16'h5555); idle(6);
        phase = "R3"; present(16'h5554); idle(HOLD + 3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule